// File: doc/BRIEF.md
# Single-Cycle Write-After-Read Wordline Sequencer

This block turns one access request into a complete read-modify-write of a memory row, all inside a single access cycle of the surrounding system. Internally it runs on a fast timing clock. It first pulses the read wordline of the addressed row and captures the whole row. It then leaves one idle tick. Finally it pulses the write wordline of the same row, which writes the captured row back with the addressed word replaced by the new data.

Because the whole row is written back, the words that were not addressed keep their contents. They are never half-selected with stale bitline values. A 3-bit margin code trims both pulse widths, so the read and write windows can be widened for slow operating conditions without changing the logic.

The old value of the addressed word is returned alongside the write. A one-tick done strobe marks the end of the write pulse. A ready output holds off new requests while an access is in flight.

Top module: `war_seq`

## Requirements
- R1: A request is taken on a timing-clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the tick after acceptance until the done tick.
- R2: The read wordline rises in the tick after acceptance and stays high for exactly margin+1 ticks, where margin is the 3-bit code (0 gives 1 tick, 7 gives 8 ticks).
- R3: At most one bit of `rwl` and at most one bit of `wwl` is ever high, and it is the bit whose index equals the accepted row address.
- R4: Exactly one tick with no wordline high separates the end of the read pulse from the start of the write pulse; the two pulses never overlap.
- R5: The write wordline stays high for exactly margin+1 ticks.
- R6: `done` is high for one tick, the tick right after the last write-pulse tick, and `req_ready` is high again in that tick; an access therefore spans 2*margin+3 ticks from acceptance to done.
- R7: The row written back equals the row read, with word `req_sel` (bits `[req_sel*16 +: 16]`) replaced by `req_wdata`; every other word of that row and every other row is unchanged.
- R8: From the idle tick onward, `rd_word` holds the value that the selected word had before the access, until the next access reads.
- R9: Row, word select, data and margin are sampled only at acceptance. Changes to them, and any request raised while busy, have no effect on the access in flight or on any other row.
- R10: After reset, no wordline is high, `done` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast timing clock; one period is one tick |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_row | input | ROW_AW | Row address |
| req_sel | input | SEL_W | Word index within the row |
| req_wdata | input | WORD_W | New word data |
| margin | input | MARGIN_W | Pulse width trim, width = code+1 ticks |
| rwl | output | ROWS | Read wordlines, one per row |
| wwl | output | ROWS | Write wordlines, one per row |
| arr_rdata | input | ROW_W | Row data read from the array |
| arr_wdata | output | ROW_W | Merged row data for writeback |
| rd_word | output | WORD_W | Old value of the addressed word |
| done | output | 1 | One-tick end-of-access strobe |

## Verification
The bench builds the sequencer with 4 rows of 8 sixteen-bit words. This keeps the sweep small enough to be exhaustive: every row, every word position and every one of the 8 margin codes is combined, 256 accesses in all. Each access is followed tick by tick against the expected pulse timeline. The behavioural array is then compared in full against an arithmetic model of the memory. On every access a competing request and a changed margin code are raised while the sequencer is busy, so the check that busy-time inputs are ignored covers all margin widths.

// File: rtl/war_seq.sv
module war_seq #(
  parameter int ROWS     = 16,
  parameter int WORDS    = 8,
  parameter int WORD_W   = 16,
  parameter int MARGIN_W = 3,
  localparam int ROW_AW  = $clog2(ROWS),
  localparam int SEL_W   = $clog2(WORDS),
  localparam int ROW_W   = WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ROW_AW-1:0]   req_row,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic [WORD_W-1:0]   req_wdata,
  input  logic [MARGIN_W-1:0] margin,
  output logic [ROWS-1:0]     rwl,
  output logic [ROWS-1:0]     wwl,
  input  logic [ROW_W-1:0]    arr_rdata,
  output logic [ROW_W-1:0]    arr_wdata,
  output logic [WORD_W-1:0]   rd_word,
  output logic                done
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_GAP, S_WRITE} state_t;

  state_t              st;
  logic [MARGIN_W-1:0] cnt, marg_q;
  logic [ROW_AW-1:0]   row_q;
  logic [SEL_W-1:0]    sel_q;
  logic [WORD_W-1:0]   wdata_q, rdw_q;
  logic [ROW_W-1:0]    line_q, merged;
  logic                done_q;
  logic [ROWS-1:0]     row_hot;

  for (genvar w = 0; w < WORDS; w++) begin : g_merge
    assign merged[w*WORD_W +: WORD_W] =
      (sel_q == SEL_W'(w)) ? wdata_q : arr_rdata[w*WORD_W +: WORD_W];
  end

  assign row_hot   = ROWS'(1) << row_q;
  assign rwl       = (st == S_READ)  ? row_hot : '0;
  assign wwl       = (st == S_WRITE) ? row_hot : '0;
  assign req_ready = (st == S_IDLE);
  assign arr_wdata = line_q;
  assign rd_word   = rdw_q;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      marg_q  <= '0;
      row_q   <= '0;
      sel_q   <= '0;
      wdata_q <= '0;
      line_q  <= '0;
      rdw_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          row_q   <= req_row;
          sel_q   <= req_sel;
          wdata_q <= req_wdata;
          marg_q  <= margin;
          cnt     <= margin;
          st      <= S_READ;
        end
        S_READ: if (cnt == '0) begin
          line_q <= merged;
          rdw_q  <= arr_rdata[sel_q*WORD_W +: WORD_W];
          st     <= S_GAP;
        end else cnt <= cnt - 1'b1;
        S_GAP: begin
          cnt <= marg_q;
          st  <= S_WRITE;
        end
        default: if (cnt == '0) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((|rwl) && (|wwl)));
  a_r3_onehot_rd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rwl));
  a_r3_onehot_wr: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wwl));
  a_r4_gap_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|rwl) |-> !(|wwl));
  a_r4_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|rwl) |=> (|wwl));
  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rwl) || (|wwl)) |-> !req_ready);
  a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(|wwl) && !(|wwl) && req_ready));
  a_r3_same_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|wwl) |-> (wwl == $past(rwl, 2)));

endmodule

// File: tb/war_seq_bench.sv
`timescale 1ns/1ps
module war_seq_bench;
  localparam int ROWS = 4, WORDS = 8, WORD_W = 16, MARGIN_W = 3;
  localparam int ROW_AW = $clog2(ROWS), SEL_W = $clog2(WORDS), ROW_W = WORDS*WORD_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, done;
  logic [ROW_AW-1:0] req_row = '0;
  logic [SEL_W-1:0] req_sel = '0;
  logic [WORD_W-1:0] req_wdata = '0, rd_word;
  logic [MARGIN_W-1:0] margin = '0;
  logic [ROWS-1:0] rwl, wwl;
  logic [ROW_W-1:0] arr_rdata, arr_wdata;

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] exp_mem [ROWS];
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  war_seq #(.ROWS(ROWS), .WORDS(WORDS), .WORD_W(WORD_W), .MARGIN_W(MARGIN_W)) u_war_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_row, .req_sel, .req_wdata,
    .margin, .rwl, .wwl, .arr_rdata, .arr_wdata, .rd_word, .done);

  always_comb begin
    arr_rdata = '0;
    for (int r = 0; r < ROWS; r++) if (rwl[r]) arr_rdata = mem[r];
  end

  always @(posedge clk)
    for (int r = 0; r < ROWS; r++) if (wwl[r]) mem[r] <= arr_wdata;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input int row, input int sel, input int m, input logic [WORD_W-1:0] data);
    int n = 2*m + 4;
    int bad_r = 0, bad_w = 0, bad_d = 0, bad_rdy = 0, bad_row = 0;
    logic [WORD_W-1:0] old_word;
    logic [ROWS-1:0] hot;
    old_word = exp_mem[row][sel*WORD_W +: WORD_W];
    hot = ROWS'(1) << row;
    @(negedge clk);
    req_valid = 1'b1; req_row = ROW_AW'(row); req_sel = SEL_W'(sel);
    req_wdata = data; margin = MARGIN_W'(m);
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 1'b0;
      if (i == 1) begin
        req_valid = 1'b1; req_row = ROW_AW'(row + 1); req_sel = SEL_W'(sel + 3);
        req_wdata = ~data; margin = MARGIN_W'(7 - m);
      end
      if (i == 2) req_valid = 1'b0;
      if ((|rwl) != (i <= m)) bad_r++;
      if ((|wwl) != (i >= m + 2 && i <= 2*m + 2)) bad_w++;
      if (done != (i == 2*m + 3)) bad_d++;
      if (i < n - 1 && req_ready != (i == 2*m + 3)) bad_rdy++;
      if (((|rwl) && rwl != hot) || ((|wwl) && wwl != hot)) bad_row++;
      if (i == 2*m + 3) check(rd_word == old_word, "R8 old word", rd_word, old_word);
      if (i == n - 1) check(rwl == '0 && wwl == '0, "R9 busy request ignored", {rwl, wwl}, 0);
    end
    check(bad_r == 0, "R2 read pulse width", bad_r, 0);
    check(bad_w == 0, "R4/R5 gap and write pulse", bad_w, 0);
    check(bad_d == 0, "R6 done strobe", bad_d, 0);
    check(bad_rdy == 0, "R1 ready", bad_rdy, 0);
    check(bad_row == 0, "R3 row select", bad_row, 0);
    exp_mem[row][sel*WORD_W +: WORD_W] = data;
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < WORDS; w++)
        check(mem[r][w*WORD_W +: WORD_W] == exp_mem[r][w*WORD_W +: WORD_W], "R7 writeback",
              mem[r][w*WORD_W +: WORD_W], exp_mem[r][w*WORD_W +: WORD_W]);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int k = 0;
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < WORDS; w++) begin
        mem[r][w*WORD_W +: WORD_W] = WORD_W'(r*4099 + w*257 + 16'h1234);
        exp_mem[r][w*WORD_W +: WORD_W] = WORD_W'(r*4099 + w*257 + 16'h1234);
      end
    repeat (3) @(negedge clk);
    check(rwl == '0 && wwl == '0, "R10 wordlines idle", {rwl, wwl}, 0);
    check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
    check(done == 1'b0, "R10 done low", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && rwl == '0, "R10 idle after reset", req_ready, 1);
    for (int m = 0; m < 8; m++)
      for (int r = 0; r < ROWS; r++)
        for (int s = 0; s < WORDS; s++) begin
          access(r, s, m, WORD_W'(k*40503 + r*8191 + s*37 + m*1009));
          k++;
        end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule